// File: doc/BRIEF.md
# Cartridge Address Decoder with Configuration Register

This block sits on the console side of a cartridge and watches a 32-bit bus address together with read and write strobes. For each access it raises at most one region select: the ROM SDRAM, the boot flash, the save EEPROM, the flash control registers or the cart registers. The selects are combinational, so a downstream memory or register file sees its select in the same cycle as the strobe.

The cart register window holds two writable registers. The enable register at index 0 gates the memory regions and drives enable bits out to neighbouring modules. The boot override register at index 1 stores a CIC type, a TV type and two spare switch bits for the bootloader. The enable register has a fixed power-up value. A console reset or NMI pulse forces the boot flash back on and turns the SDRAM and bus-side EEPROM windows off, so the console always restarts from the bootloader.

When SDRAM is enabled, the flash window moves from 0x1000_0000 to 0x1800_0000. This keeps the two regions from overlapping.

Top module: `cart_addr_decoder`

## Requirements
- R1: After power-on reset, the enable register reads 0x0000_0001, the boot override register reads 0, and `cfg_bits` equals 6'b000001.
- R2: `sel[0]` (SDRAM) rises for a read or a write in 0x1000_0000 to 0x13FF_FFFF, but only while enable bit 1 is set.
- R3: `sel[1]` (flash) rises for a read in the 16 MB window whose base is 0x1000_0000 when enable bit 1 is clear and 0x1800_0000 when it is set. This happens only while enable bit 0 is set.
- R4: A write into the flash window never raises any select.
- R5: `sel[2]` (EEPROM) rises for an access in the 2 kB window at 0x1D00_0000 while enable bit 2 is set, and only when address bits 1:0 are zero.
- R6: `sel[3]` covers the flash register window 0x1C00_0000 to 0x1C00_00FF. `sel[4]` covers the cart register window 0x1E00_0000 to 0x1E00_00FF. Both are always available, and `reg_rdata` is zero for a flash register access.
- R7: A write at cart offset 0x00 stores data bits 5:0 into the enable register. Bits 31:6 read as zero. Enable bits are 5 debug, 4 EEPROM size, 3 serial EEPROM, 2 bus EEPROM, 1 SDRAM, 0 flash, and they appear on `cfg_bits`.
- R8: A console reset pulse clears enable bits 2 and 1, sets bit 0 and keeps bits 5:3. It overrides a register write in the same cycle.
- R9: A write at cart offset 0x04 stores data bits 7:0 (switch 7:6, TV type 5:4, CIC type 3:0). Bits 31:8 read as zero. Other cart offsets read as zero.
- R10: An access that hits no enabled region raises no select, and `reg_rdata` is zero.
- R11: `sel` has at most one bit set. With neither strobe active, `sel` and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| console_rst | input | 1 | Console reset/NMI pulse, one cycle |
| bus_addr | input | 32 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| sel | output | 5 | Region selects: 0 SDRAM, 1 flash, 2 EEPROM, 3 flash regs, 4 cart regs |
| reg_rdata | output | 32 | Cart register read data |
| cfg_bits | output | 6 | Enable register bits 5:0 |
| boot_ovr | output | 8 | Boot override register bits 7:0 |

## Verification
Addresses are swept across each window's first and last word and the first word beyond it. Each sweep runs under three enable settings: power-up, all bits set, and SDRAM without flash. This separates a range error from a gating error and shows whether the flash base moves with the SDRAM bit. Writes are aimed at flash under both bases, to catch a write that wrongly raises the read-only select. A console reset is applied twice: once together with a conflicting register write, and once alone after the upper enable bits have been cleared. This shows both the override priority and which bits survive the pulse.

// File: rtl/cart_addr_decoder.sv
module cart_addr_decoder #(
  parameter logic [5:0]  SDRAM_TAG  = 6'h04,
  parameter logic [7:0]  FLASH_LO   = 8'h10,
  parameter logic [7:0]  FLASH_HI   = 8'h18,
  parameter logic [20:0] EEP_TAG    = 21'h03A000,
  parameter logic [23:0] FREG_TAG   = 24'h1C0000,
  parameter logic [23:0] CREG_TAG   = 24'h1E0000,
  parameter int          CFG_W      = 6,
  parameter int          OVR_W      = 8,
  parameter logic [CFG_W-1:0] CFG_INIT = 6'b000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              console_rst,
  input  logic [31:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [4:0]        sel,
  output logic [31:0]       reg_rdata,
  output logic [CFG_W-1:0]  cfg_bits,
  output logic [OVR_W-1:0]  boot_ovr
);

  localparam int BIT_FLASH = 0;
  localparam int BIT_SDRAM = 1;
  localparam int BIT_EEP   = 2;

  logic [CFG_W-1:0] cfg_q;
  logic [OVR_W-1:0] ovr_q;
  logic             acc;
  logic             hit_sdram, hit_flash, hit_eep, hit_freg, hit_creg;
  logic [5:0]       creg_idx;

  assign acc      = bus_rd | bus_wr;
  assign creg_idx = bus_addr[7:2];

  assign hit_sdram = cfg_q[BIT_SDRAM] && bus_addr[31:26] == SDRAM_TAG;
  assign hit_flash = cfg_q[BIT_FLASH] && !bus_wr &&
                     bus_addr[31:24] == (cfg_q[BIT_SDRAM] ? FLASH_HI : FLASH_LO);
  assign hit_eep   = cfg_q[BIT_EEP] && bus_addr[31:11] == EEP_TAG && bus_addr[1:0] == 2'b00;
  assign hit_freg  = bus_addr[31:8] == FREG_TAG;
  assign hit_creg  = bus_addr[31:8] == CREG_TAG;

  assign sel = acc ? {hit_creg, hit_freg, hit_eep, hit_flash, hit_sdram} : 5'b0;

  always_comb begin
    reg_rdata = '0;
    if (bus_rd && hit_creg) begin
      case (creg_idx)
        6'd0:    reg_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
        6'd1:    reg_rdata = {{(32-OVR_W){1'b0}}, ovr_q};
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_INIT;
      ovr_q <= '0;
    end else begin
      if (console_rst) begin
        cfg_q[BIT_FLASH] <= 1'b1;
        cfg_q[BIT_SDRAM] <= 1'b0;
        cfg_q[BIT_EEP]   <= 1'b0;
      end else if (bus_wr && hit_creg && creg_idx == 6'd0) begin
        cfg_q <= bus_wdata[CFG_W-1:0];
      end
      if (bus_wr && hit_creg && creg_idx == 6'd1)
        ovr_q <= bus_wdata[OVR_W-1:0];
    end
  end

  assign cfg_bits = cfg_q;
  assign boot_ovr = ovr_q;

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (sel == 5'b0 && reg_rdata == 32'b0));
  assert_no_flash_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !sel[1]);
  assert_sdram_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bits[BIT_SDRAM] |-> !sel[0]);
  assert_eep_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel[2] |-> (cfg_bits[BIT_EEP] && bus_addr[1:0] == 2'b00));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == 5'b0) |-> reg_rdata == 32'b0);
  assert_console_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    console_rst |=> (cfg_bits[2:0] == 3'b001 && cfg_bits[5:3] == $past(cfg_bits[5:3])));

endmodule

// File: tb/cart_addr_decoder_tb.sv
module cart_addr_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        console_rst = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [4:0]  sel;
  logic [31:0] reg_rdata;
  logic [5:0]  cfg_bits;
  logic [7:0]  boot_ovr;

  always #2 clk = ~clk;

  cart_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .console_rst(console_rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .sel(sel), .reg_rdata(reg_rdata), .cfg_bits(cfg_bits), .boot_ovr(boot_ovr)
  );

  typedef struct {
    logic [4:0]  sel;
    logic [31:0] rdata;
    logic [5:0]  cfg;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  logic [5:0] m_cfg = 6'b000001;
  bit done = 0;

  localparam logic [31:0] CREG = 32'h1E00_0000;

  task automatic access(input logic [31:0] a, input logic rd, input logic wr,
                        input logic [31:0] wd, input logic crst,
                        input logic [4:0] es, input logic [31:0] er, input string req);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; console_rst = crst;
    it.sel = es; it.rdata = er; it.cfg = m_cfg; it.req = req;
    q.push_back(it);
    if (crst) m_cfg = {m_cfg[5:3], 3'b001};
    else if (wr && a == CREG) m_cfg = wd[5:0];
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (sel !== it.sel || reg_rdata !== it.rdata || cfg_bits !== it.cfg) begin
          fails++;
          $display("FAIL %s: sel=%b rdata=%h cfg=%b expected sel=%b rdata=%h cfg=%b",
                   it.req, sel, reg_rdata, cfg_bits, it.sel, it.rdata, it.cfg);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    access(32'h0, 0, 0, 0, 0, 5'b00000, 0, "R1 idle after reset");
    access(CREG, 1, 0, 0, 0, 5'b10000, 32'h1, "R1 enable reg power-up");
    access(CREG + 4, 1, 0, 0, 0, 5'b10000, 32'h0, "R1 override reg power-up");
    // R3/R4 flash low base, SDRAM off
    access(32'h1000_0000, 1, 0, 0, 0, 5'b00010, 0, "R3 flash low base");
    access(32'h10FF_FFFE, 1, 0, 0, 0, 5'b00010, 0, "R3 flash low top");
    access(32'h1000_0000, 0, 1, 32'h55, 0, 5'b00000, 0, "R4 flash write low");
    access(32'h1200_0000, 1, 0, 0, 0, 5'b00000, 0, "R10 SDRAM range disabled");
    access(32'h1800_0000, 1, 0, 0, 0, 5'b00000, 0, "R3 high base unused");
    access(32'h1D00_0000, 1, 0, 0, 0, 5'b00000, 0, "R5 EEPROM disabled");
    // R7 enable all
    access(CREG, 0, 1, 32'hFFFF_FFFF, 0, 5'b10000, 0, "R7 write enable reg");
    access(CREG, 1, 0, 0, 0, 5'b10000, 32'h3F, "R7 readback upper zero");
    // R2 SDRAM
    access(32'h1000_0000, 1, 0, 0, 0, 5'b00001, 0, "R2 SDRAM base");
    access(32'h13FF_FFFC, 0, 1, 32'h1, 0, 5'b00001, 0, "R2 SDRAM top write");
    access(32'h1400_0000, 1, 0, 0, 0, 5'b00000, 0, "R10 past SDRAM");
    access(32'h1800_0000, 1, 0, 0, 0, 5'b00010, 0, "R3 flash high base");
    access(32'h18FF_FFFE, 1, 0, 0, 0, 5'b00010, 0, "R3 flash high top");
    access(32'h1900_0000, 1, 0, 0, 0, 5'b00000, 0, "R10 past flash high");
    access(32'h1800_0000, 0, 1, 32'h2, 0, 5'b00000, 0, "R4 flash write high");
    // R5 EEPROM
    access(32'h1D00_0000, 1, 0, 0, 0, 5'b00100, 0, "R5 EEPROM base");
    access(32'h1D00_07FC, 0, 1, 32'h3, 0, 5'b00100, 0, "R5 EEPROM top");
    access(32'h1D00_0800, 1, 0, 0, 0, 5'b00000, 0, "R10 past EEPROM");
    access(32'h1D00_0002, 1, 0, 0, 0, 5'b00000, 0, "R5 EEPROM misaligned");
    // R6 register windows
    access(32'h1C00_0000, 1, 0, 0, 0, 5'b01000, 0, "R6 flash regs");
    access(32'h1C00_0100, 1, 0, 0, 0, 5'b00000, 0, "R10 past flash regs");
    access(32'h0000_0000, 1, 0, 0, 0, 5'b00000, 0, "R10 low unmapped");
    // R9 override reg
    access(CREG + 4, 0, 1, 32'hFFFF_FFA5, 0, 5'b10000, 0, "R9 write override");
    access(CREG + 4, 1, 0, 0, 0, 5'b10000, 32'hA5, "R9 override readback");
    access(CREG + 8, 1, 0, 0, 0, 5'b10000, 32'h0, "R9 other offset zero");
    // R8 console reset beats write
    access(CREG, 0, 1, 32'h0, 1, 5'b10000, 0, "R8 reset with write");
    access(CREG, 1, 0, 0, 0, 5'b10000, 32'h39, "R8 bits 5:3 kept");
    access(32'h1000_0000, 1, 0, 0, 0, 5'b00010, 0, "R8 flash back low");
    // SDRAM without flash
    access(CREG, 0, 1, 32'h06, 0, 5'b10000, 0, "R7 write 0x06");
    access(32'h1000_0000, 1, 0, 0, 0, 5'b00001, 0, "R2 SDRAM no flash");
    access(32'h1800_0000, 1, 0, 0, 0, 5'b00000, 0, "R3 flash disabled");
    access(32'h1D00_0004, 1, 0, 0, 0, 5'b00100, 0, "R5 EEPROM on");
    access(32'h0, 0, 0, 0, 1, 5'b00000, 0, "R8 reset alone");
    access(CREG, 1, 0, 0, 0, 5'b10000, 32'h01, "R8 after reset alone");
    access(CREG, 0, 0, 0, 0, 5'b00000, 0, "R11 no strobe");
    access(32'h1000_0000, 1, 1, 0, 0, 5'b00000, 0, "R11 R4 both strobes flash");
    access(32'h0, 0, 0, 0, 0, 5'b00000, 0, "R11 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule